// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Aligner

This block sits after the receive descrambler of a 100 Mb/s physical layer. It takes 5-bit groups whose boundaries bear no fixed relation to the code-group boundaries of the line code, one group per symbol clock. It then recovers the code-group framing by looking for the start-of-stream delimiter pair (J then K) in the serial bit sequence. Every bit offset within a group is tried, so the pair is found wherever it lands.

When the pair is seen, the aligner freezes the boundary it implies and emits aligned 5-bit code-groups, starting with J and then K. Each output carries a valid strobe. The boundary stays fixed until a resynchronise request arrives or until the line returns to idle, which is two consecutive aligned IDLE code-groups. The block then returns to searching. The detected offset is reported so that later stages can monitor how the link frames.

Top module: `sym_aligner`

## Requirements
- R1: While `rst` is high, and after it is released until a delimiter is found, `sym_locked` and `sym_out_vld` are 0, and `det_ofs` reads 0.
- R2: The first-arriving bit of a group is `grp_in[4]`. The delimiter is J = 11000 followed by K = 10001 in arrival order. The offset is the bit position (0 = `grp_in[4]`, 4 = `grp_in[0]`) of J's first bit within its input group. Every offset 0 to 4 is detected.
- R3: A delimiter is recognised on the valid group that arrives two groups after the group that holds J's first bit. At that clock edge, `sym_locked` and `sym_out_vld` become 1, `sym_out` shows J and `det_ofs` shows the offset.
- R4: While locked, each valid input group produces, one clock later, the next five stream bits on the fixed boundary, earliest bit in bit 4. The first group after J is K.
- R5: A cycle with `grp_in_vld` low gives `sym_out_vld` low at the next edge and consumes no bits.
- R6: While searching, `sym_out_vld` stays low.
- R7: When two aligned IDLE groups (11111) are emitted on consecutive valid inputs, the second is still emitted with `sym_out_vld` high, and `sym_locked` falls at that same edge. A non-IDLE group between two IDLE groups restarts the count.
- R8: `resync_req` clears `sym_locked` and `sym_out_vld` at the next edge. It wins over a delimiter match in the same cycle. It does not clear the bit history.
- R9: While locked, no search takes place, and `det_ofs` holds its value until the next lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_in | input | 5 | Unaligned descrambled bit group, bit 4 first |
| grp_in_vld | input | 1 | `grp_in` carries a new group this cycle |
| resync_req | input | 1 | Drop lock and search again |
| sym_out | output | 5 | Aligned code-group, bit 4 first |
| sym_out_vld | output | 1 | `sym_out` is a new aligned code-group |
| sym_locked | output | 1 | Boundary is frozen |
| det_ofs | output | 3 | Bit offset of the last detected delimiter |

## Verification
Two functions can fall in the same clock edge: a delimiter match completing, and a resynchronise request. The bench has a mode that predicts, from its own bit-stream model, the group that will complete a match, and raises `resync_req` in exactly that cycle. It then expects the aligner to stay unlocked with no output. It also expects the same delimiter not to be found again later, because the bits have been consumed. A second overlap is the release by IDLE groups and a following delimiter. Random streams with injected delimiters exercise this case, and the model judges each cycle.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic {
    SA_SEARCH = 1'b0,
    SA_LOCK   = 1'b1
  } sa_state_e;
endpackage

// File: rtl/sa_history.sv
// Shift register of the last NG groups, oldest group in the top bits.
module sa_history #(
  parameter int GW = 5,
  parameter int NG = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift,
  input  logic [GW-1:0]      din,
  output logic [NG*GW-1:0]   hist
);
  localparam int HW = NG * GW;

  generate
    if (NG == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)        hist <= '0;
        else if (shift) hist <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)        hist <= '0;
        else if (shift) hist <= {hist[HW-GW-1:0], din};
      end
    end
  endgenerate
endmodule

// File: rtl/sa_matcher.sv
// Tests the delimiter pair at every bit offset of the window; lowest offset wins.
module sa_matcher #(
  parameter int                 GW    = 5,
  parameter int                 WIN_W = 15,
  parameter int                 PW    = 10,
  parameter logic [PW-1:0]      PAIR  = 10'b1100010001,
  parameter int                 OFS_W = 3
) (
  input  logic [WIN_W-1:0]  win,
  output logic              hit,
  output logic [OFS_W-1:0]  hit_ofs
);
  logic [GW-1:0] hits;

  genvar s;
  generate
    for (s = 0; s < GW; s++) begin : g_ofs
      assign hits[s] = (win[WIN_W-1-s -: PW] == PAIR);
    end
  endgenerate

  always_comb begin
    hit_ofs = '0;
    for (int k = GW - 1; k >= 0; k--) begin
      if (hits[k]) hit_ofs = OFS_W'(k);
    end
  end

  assign hit = |hits;
endmodule

// File: rtl/sa_slicer.sv
// Picks the GW-bit group starting at the selected offset of the window.
module sa_slicer #(
  parameter int GW    = 5,
  parameter int WIN_W = 15,
  parameter int OFS_W = 3
) (
  input  logic [WIN_W-1:0] win,
  input  logic [OFS_W-1:0] sel,
  output logic [GW-1:0]    grp
);
  logic [GW-1:0] cand [GW];

  genvar s;
  generate
    for (s = 0; s < GW; s++) begin : g_cand
      assign cand[s] = win[WIN_W-1-s -: GW];
    end
  endgenerate

  always_comb begin
    grp = cand[0];
    for (int k = 1; k < GW; k++) begin
      if (sel == OFS_W'(k)) grp = cand[k];
    end
  end
endmodule

// File: rtl/sa_lockctl.sv
// Search/lock state, idle-run release and registered aligned output.
module sa_lockctl
  import sa_pkg::*;
#(
  parameter int            GW       = 5,
  parameter int            OFS_W    = 3,
  parameter logic [GW-1:0] IDLE_GRP = 5'b11111,
  parameter int            IDLE_RUN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              resync,
  input  logic              hit,
  input  logic [OFS_W-1:0]  hit_ofs,
  input  logic [GW-1:0]     aligned,
  output logic [OFS_W-1:0]  sel_ofs,
  output logic [GW-1:0]     out_grp,
  output logic              out_vld,
  output logic              locked,
  output logic [OFS_W-1:0]  offset
);
  localparam int CNT_W = $clog2(IDLE_RUN + 1);

  sa_state_e        state;
  logic [CNT_W-1:0] idle_cnt;

  assign locked  = (state == SA_LOCK);
  assign sel_ofs = locked ? offset : hit_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SA_SEARCH;
      out_grp  <= '0;
      out_vld  <= 1'b0;
      offset   <= '0;
      idle_cnt <= '0;
    end else begin
      out_vld <= 1'b0;
      if (resync) begin
        state    <= SA_SEARCH;
        idle_cnt <= '0;
      end else if (in_vld) begin
        if (state == SA_SEARCH) begin
          if (hit) begin
            state    <= SA_LOCK;
            offset   <= hit_ofs;
            out_grp  <= aligned;
            out_vld  <= 1'b1;
            idle_cnt <= '0;
          end
        end else begin
          out_grp <= aligned;
          out_vld <= 1'b1;
          if (aligned == IDLE_GRP) begin
            if (idle_cnt == CNT_W'(IDLE_RUN - 1)) begin
              state    <= SA_SEARCH;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end else begin
            idle_cnt <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sym_aligner.sv
module sym_aligner #(
  parameter int                    GRP_W    = 5,
  parameter logic [2*GRP_W-1:0]    PAIR     = 10'b1100010001,
  parameter logic [GRP_W-1:0]      IDLE_GRP = 5'b11111,
  parameter int                    IDLE_RUN = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [GRP_W-1:0]           grp_in,
  input  logic                       grp_in_vld,
  input  logic                       resync_req,
  output logic [GRP_W-1:0]           sym_out,
  output logic                       sym_out_vld,
  output logic                       sym_locked,
  output logic [$clog2(GRP_W)-1:0]   det_ofs
);
  localparam int PW    = 2 * GRP_W;
  localparam int HW    = 2 * GRP_W;
  localparam int WIN_W = HW + GRP_W;
  localparam int OFS_W = $clog2(GRP_W);

  logic [HW-1:0]    hist;
  logic [WIN_W-1:0] win;
  logic             hit;
  logic [OFS_W-1:0] hit_ofs;
  logic [OFS_W-1:0] sel_ofs;
  logic [GRP_W-1:0] aligned;

  assign win = {hist, grp_in};

  sa_history #(.GW(GRP_W), .NG(2)) u_hist (
    .clk(clk), .rst(rst), .shift(grp_in_vld), .din(grp_in), .hist(hist)
  );

  sa_matcher #(.GW(GRP_W), .WIN_W(WIN_W), .PW(PW), .PAIR(PAIR), .OFS_W(OFS_W)) u_match (
    .win(win), .hit(hit), .hit_ofs(hit_ofs)
  );

  sa_slicer #(.GW(GRP_W), .WIN_W(WIN_W), .OFS_W(OFS_W)) u_slice (
    .win(win), .sel(sel_ofs), .grp(aligned)
  );

  sa_lockctl #(.GW(GRP_W), .OFS_W(OFS_W), .IDLE_GRP(IDLE_GRP), .IDLE_RUN(IDLE_RUN)) u_ctl (
    .clk(clk), .rst(rst), .in_vld(grp_in_vld), .resync(resync_req),
    .hit(hit), .hit_ofs(hit_ofs), .aligned(aligned), .sel_ofs(sel_ofs),
    .out_grp(sym_out), .out_vld(sym_out_vld), .locked(sym_locked), .offset(det_ofs)
  );
endmodule

// File: rtl/sym_aligner_chk.sv
module sym_aligner_chk #(
  parameter int                  GRP_W    = 5,
  parameter logic [2*GRP_W-1:0]  PAIR     = 10'b1100010001,
  parameter logic [GRP_W-1:0]    IDLE_GRP = 5'b11111
) (
  input logic                      clk,
  input logic                      rst,
  input logic [GRP_W-1:0]          grp_in,
  input logic                      grp_in_vld,
  input logic                      resync_req,
  input logic [GRP_W-1:0]          sym_out,
  input logic                      sym_out_vld,
  input logic                      sym_locked,
  input logic [$clog2(GRP_W)-1:0]  det_ofs
);
  // R8
  resync_drop_chk: assert property (@(posedge clk) disable iff (rst)
    resync_req |=> (!sym_locked && !sym_out_vld));

  // R5
  idle_input_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_in_vld |=> !sym_out_vld);

  // R3
  first_is_j_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sym_locked) |-> (sym_out_vld && sym_out == PAIR[2*GRP_W-1 -: GRP_W]));

  // R7
  unlocked_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_out_vld && !sym_locked) |-> ($past(sym_locked) && sym_out == IDLE_GRP));

  // R9
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sym_locked |=> $stable(det_ofs));

  // R2
  offset_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(det_ofs) < GRP_W);
endmodule

bind sym_aligner sym_aligner_chk #(.GRP_W(GRP_W), .PAIR(PAIR), .IDLE_GRP(IDLE_GRP)) u_chk (
  .clk(clk), .rst(rst), .grp_in(grp_in), .grp_in_vld(grp_in_vld),
  .resync_req(resync_req), .sym_out(sym_out), .sym_out_vld(sym_out_vld),
  .sym_locked(sym_locked), .det_ofs(det_ofs)
);

// File: tb/sym_aligner_test.sv
module sym_aligner_test;
  localparam logic [9:0] PAIR_C = 10'b1100010001;
  localparam logic [4:0] IDLE_C = 5'b11111;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] grp_in = '0;
  logic       grp_in_vld = 1'b0;
  logic       resync_req = 1'b0;
  logic [4:0] sym_out;
  logic       sym_out_vld;
  logic       sym_locked;
  logic [2:0] det_ofs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sym_aligner uut (
    .clk(clk), .rst(rst), .grp_in(grp_in), .grp_in_vld(grp_in_vld),
    .resync_req(resync_req), .sym_out(sym_out), .sym_out_vld(sym_out_vld),
    .sym_locked(sym_locked), .det_ofs(det_ofs)
  );

  // bit-stream model of the requirements
  bit   sbits [0:32767];
  int   nbits = 0;
  int   ngrp = 0;
  bit   m_locked = 0;
  int   m_pos = 0;
  int   m_ofs = 0;
  int   m_idle = 0;
  bit   rs_on_match = 0;
  // transmit bit buffer
  bit   txq [0:4];
  int   txn = 0;
  int   gap_pct = 0;

  function automatic bit pair_at(int b);
    for (int i = 0; i < 10; i++)
      if (sbits[b + i] != PAIR_C[9 - i]) return 0;
    return 1;
  endfunction

  function automatic logic [4:0] grp_at(int b);
    logic [4:0] g;
    for (int i = 0; i < 5; i++) g[4 - i] = sbits[b + i];
    return g;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (group %0d)", tag, what, act, exp, ngrp);
    end
  endtask

  task automatic send(logic [4:0] g, bit vld, bit rs);
    bit   found = 0;
    int   fofs = 0;
    bit   exp_vld = 0;
    logic [4:0] exp_grp = '0;
    bit   was_locked = m_locked;
    string tag;
    if (vld) begin
      for (int i = 0; i < 5; i++) sbits[nbits + i] = g[4 - i];
      if (!m_locked && ngrp >= 2)
        for (int s = 0; s < 5; s++)
          if (!found && pair_at(5 * (ngrp - 2) + s)) begin found = 1; fofs = s; end
    end
    if (rs_on_match && found) rs = 1;
    tag = vld ? (m_locked ? "R4" : "R6") : "R5";
    if (rs) begin
      m_locked = 0; m_idle = 0; tag = "R8";
    end else if (vld) begin
      if (!m_locked) begin
        if (found) begin
          m_locked = 1; m_ofs = fofs; m_idle = 0;
          exp_vld = 1; exp_grp = grp_at(5 * (ngrp - 2) + fofs);
          m_pos = 5 * (ngrp - 2) + fofs + 5; tag = "R3";
        end
      end else begin
        exp_vld = 1; exp_grp = grp_at(m_pos); m_pos += 5;
        if (exp_grp == IDLE_C) begin
          m_idle++;
          if (m_idle == 2) begin m_locked = 0; m_idle = 0; tag = "R7"; end
        end else m_idle = 0;
      end
    end
    if (vld) begin nbits += 5; ngrp++; end
    grp_in = g; grp_in_vld = vld; resync_req = rs;
    @(posedge clk);
    #2;
    chk(tag, "out_vld", int'(sym_out_vld), int'(exp_vld));
    chk(tag, "locked", int'(sym_locked), int'(m_locked));
    if (exp_vld) chk(tag, "sym_out", int'(sym_out), int'(exp_grp));
    chk((tag == "R3") ? "R2" : (was_locked ? "R9" : tag), "det_ofs", int'(det_ofs), m_ofs);
    @(negedge clk);
  endtask

  task automatic push_bit(bit b);
    txq[txn] = b; txn++;
    if (txn == 5) begin
      logic [4:0] g;
      for (int i = 0; i < 5; i++) g[4 - i] = txq[i];
      txn = 0;
      while (($urandom % 100) < gap_pct) send($urandom, 0, 0);
      send(g, 1, 0);
    end
  endtask

  task automatic push_bits(logic [9:0] v, int n);
    for (int i = n - 1; i >= 0; i--) push_bit(v[i]);
  endtask

  task automatic pad_to_group();
    while (txn != 0) push_bit(0);
  endtask

  task automatic frame(int ofs, int ndata);
    push_bits(10'd0, 10);
    pad_to_group();
    push_bits(10'd0, ofs);
    push_bits(PAIR_C, 10);
    for (int i = 0; i < ndata; i++) push_bits(10'($urandom % 31), 5);
    push_bits(10'h3FF, 10);
    push_bits(10'd0, 10);
    pad_to_group();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "locked", int'(sym_locked), 0);
    chk("R1", "out_vld", int'(sym_out_vld), 0);
    chk("R1", "det_ofs", int'(det_ofs), 0);
    @(negedge clk);
    rst = 1'b0;
    // R2 R3 R4 R7: every offset with a clean frame
    for (int s = 0; s < 5; s++) frame(s, 6);
    // R5: valid gaps inside frames
    gap_pct = 30;
    for (int s = 4; s >= 0; s--) frame(s, 5);
    gap_pct = 0;
    // R7: IDLE groups separated by data keep the lock
    push_bits(10'd0, 10); pad_to_group();
    push_bits(PAIR_C, 10);
    push_bits(10'h1F, 5); push_bits(10'h05, 5);
    push_bits(10'h1F, 5); push_bits(10'h0A, 5);
    push_bits(10'h3FF, 10);
    push_bits(10'd0, 10); pad_to_group();
    // R8: resync while locked, then a frame is found again
    push_bits(PAIR_C, 10);
    push_bits(10'h06, 5);
    send(5'h09, 1, 1);
    send(5'h03, 1, 0);
    frame(2, 3);
    // R8: resync in the very cycle that completes a match
    rs_on_match = 1;
    frame(1, 3);
    frame(3, 3);
    rs_on_match = 0;
    frame(0, 2);
    // random streams with injected delimiters, gaps and resyncs
    gap_pct = 10;
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom % 100;
      if (r < 8) push_bits(PAIR_C, 10);
      else if (r < 14) push_bits(10'h3FF, 10);
      else if (r < 16) send($urandom, $urandom % 2, 1);
      else push_bit($urandom % 2);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule